// File: doc/BRIEF.md
# Down-Counter Video Timing Generator

This block produces raster timing for a video output: a horizontal sync level, a vertical sync level, a display-enable level and a linear pixel address into a frame buffer. It does not compare one running position counter against a list of limits. Each timing edge has its own presettable down-counter. All counters of an axis reload together when a new line (or frame) begins, and each counts down to zero. The step into zero is that edge's single event. A small three-state window machine per level opens on one event and closes on another.

The horizontal axis steps once per character of `CHAR_PIX` pixel clocks, so its 8-bit counters can span a full line. The vertical axis uses the same structure and steps once per line. The address output is a per-line pixel offset added to a frame-relative line base. The offset counts only pixels where display enable is high. All presets are input ports. An axis samples its inputs only at its own reload, so a change takes effect on the next line (horizontal) or the next frame (vertical). The package carries preset values for a 640x480 picture inside an 800 x 525 total. With 8-pixel characters, the horizontal line total preset is 99 and the vertical frame total preset is 524.

The window machine has three states. `WIN_BEFORE` means the opening event has not yet happened in this line or frame. `WIN_INSIDE` means the level is high. `WIN_AFTER` means the closing event has happened. Three transitions move between them. *reload* enters `WIN_AFTER` if the close preset is zero, otherwise `WIN_INSIDE` if the open preset is zero, otherwise `WIN_BEFORE`. *open* goes from `WIN_BEFORE` to `WIN_INSIDE` on the opening event. *close* goes from any state to `WIN_AFTER` on the closing event. If open and close happen on the same step, close wins.

Top module: `vtg_timing_gen`

## Requirements
- R1: On the clock edge where the synchronous reset `rst` is high, the block enters pixel 0 of line 0 of a new frame. It loads every counter from the preset inputs. `pix_addr` reads 0 at the first visible pixel after reset.
- R2: Horizontal timing moves in characters of `CHAR_PIX` pixel clocks. A line lasts (`h_total`+1)×`CHAR_PIX` clocks. `hsync` and the horizontal visible level change only on character boundaries.
- R3: Let c be the character index within the line, starting at 0. `hsync` is high exactly when `h_sync_on` ≤ c < `h_sync_off`. If `h_sync_off` ≤ `h_sync_on`, `hsync` stays low for the whole line. Each event counter fires once and then holds at zero until the next reload.
- R4: `de` is high exactly when `h_vis_on` ≤ c < `h_vis_off` and the line is inside the vertical visible window.
- R5: A frame lasts `v_total`+1 lines. Let y be the line index within the frame. `vsync` is high exactly when `v_sync_on` ≤ y < `v_sync_off`. The visible lines are those with `v_vis_on` ≤ y < `v_vis_off`. Vertical levels change only where a line begins.
- R6: Horizontal preset inputs are sampled only at the edge that starts a line. Vertical preset inputs are sampled only at the edge that starts a frame. A change made at any other time has no effect until the next such edge.
- R7: At every pixel where `de` is high, `pix_addr` equals the number of `de`-high pixels earlier in the same frame. This includes a visible region that runs to the last pixel of a line.
- R8: An event whose preset exceeds the axis total never fires in that line or frame. A window whose close preset is beyond the total therefore stays open to the end of the line or frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | H_CW | Characters per line minus one |
| h_sync_on | input | H_CW | Character index where hsync goes high |
| h_sync_off | input | H_CW | Character index where hsync goes low |
| h_vis_on | input | H_CW | Character index where the horizontal visible region begins |
| h_vis_off | input | H_CW | Character index where the horizontal visible region ends |
| v_total | input | V_CW | Lines per frame minus one |
| v_sync_on | input | V_CW | Line where vsync goes high |
| v_sync_off | input | V_CW | Line where vsync goes low |
| v_vis_on | input | V_CW | First visible line |
| v_vis_off | input | V_CW | Line where the vertical visible region ends |
| hsync | output | 1 | Horizontal sync level, active high |
| vsync | output | 1 | Vertical sync level, active high |
| de | output | 1 | Display enable |
| pix_addr | output | ADDR_W | Linear address of the current visible pixel |

## Verification
Errors inside this block show up directly on the output levels, one character or one line after they occur. A counter that reloads late, steps twice, or restarts from zero shifts an hsync or de edge by a whole character within the same line. A window machine stuck in the wrong state keeps a level high or low for the rest of the line. A faulty line base or offset shows up at the next visible pixel as a `pix_addr` that is not one more than the previous value. The bench models the raster from the requirements and compares every output on every clock. It covers reset, a preset change in the middle of a line, empty and unbounded windows, and the widest possible line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Level window state: before opening, open, closed
    typedef enum logic [1:0] {
        WIN_BEFORE = 2'd0,
        WIN_INSIDE = 2'd1,
        WIN_AFTER  = 2'd2
    } win_state_e;

    // 640x480 preset set, horizontal in 8-pixel characters
    localparam int unsigned DEF_CHAR_PIX   = 8;
    localparam int unsigned DEF_H_TOTAL    = 99;   // 100 chars = 800 px
    localparam int unsigned DEF_H_VIS_ON   = 0;
    localparam int unsigned DEF_H_VIS_OFF  = 80;   // 640 px
    localparam int unsigned DEF_H_SYNC_ON  = 82;   // 16 px porch
    localparam int unsigned DEF_H_SYNC_OFF = 94;   // 96 px sync
    localparam int unsigned DEF_V_TOTAL    = 524;  // 525 lines
    localparam int unsigned DEF_V_VIS_ON   = 0;
    localparam int unsigned DEF_V_VIS_OFF  = 480;
    localparam int unsigned DEF_V_SYNC_ON  = 490;
    localparam int unsigned DEF_V_SYNC_OFF = 492;

endpackage

// File: rtl/vtg_evt_cnt.sv
module vtg_evt_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic [CW-1:0] preset,
    output logic          fire
);
    logic [CW-1:0] cnt_q;

    // Event: preset of zero at reload, or a step from one into zero
    always_comb begin
        if (load) begin
            fire = (preset == '0);
        end else begin
            fire = adv && (cnt_q == CW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            cnt_q <= preset;
        end else if (adv && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R3: a counter at zero stays there until reloaded
    a_r3_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

    // R3: one step per advance while nonzero
    a_r3_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/vtg_window.sv
module vtg_window
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic open_fire,
    input  logic close_fire,
    output logic active
);
    win_state_e state_q;
    win_state_e state_d;
    win_state_e base_s;

    // Next-state process
    always_comb begin
        base_s = load ? WIN_BEFORE : state_q;
        state_d = base_s;
        unique case (base_s)
            WIN_BEFORE: begin
                if (close_fire) begin
                    state_d = WIN_AFTER;
                end else if (open_fire) begin
                    state_d = WIN_INSIDE;
                end
            end
            WIN_INSIDE: begin
                if (close_fire) begin
                    state_d = WIN_AFTER;
                end
            end
            WIN_AFTER: begin
                state_d = WIN_AFTER;
            end
            default: begin
                state_d = WIN_BEFORE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Output process
    always_comb begin
        active = (state_q == WIN_INSIDE);
    end

    // R3: once closed, the window stays closed until the next reload
    a_r3_closed_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_AFTER && !load) |=> (state_q == WIN_AFTER));

    // R3: an open window does not fall back to the pre-open state without reload
    a_r3_no_reopen: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_INSIDE && !load) |=> (state_q != WIN_BEFORE));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [CW-1:0] total,
    input  logic [CW-1:0] sync_on,
    input  logic [CW-1:0] sync_off,
    input  logic [CW-1:0] vis_on,
    input  logic [CW-1:0] vis_off,
    output logic          sync_lvl,
    output logic          vis_lvl,
    output logic          wrap
);
    localparam int unsigned N_EVT = 4;
    localparam int unsigned N_WIN = N_EVT / 2;

    logic [CW-1:0]    tot_q;
    logic             load;
    logic [CW-1:0]    presets [N_EVT];
    logic [N_EVT-1:0] fires;
    logic [N_WIN-1:0] levels;

    assign wrap = adv && (tot_q == '0);
    assign load = rst || wrap;

    // Span counter: reloads at axis start, counts down per step
    always_ff @(posedge clk) begin
        if (load) begin
            tot_q <= total;
        end else if (adv) begin
            tot_q <= tot_q - CW'(1);
        end
    end

    // Event order: even index opens a window, odd index closes it
    assign presets[0] = sync_on;
    assign presets[1] = sync_off;
    assign presets[2] = vis_on;
    assign presets[3] = vis_off;

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        vtg_evt_cnt #(.CW(CW)) evt_i (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .adv    (adv),
            .preset (presets[e]),
            .fire   (fires[e])
        );
    end

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        vtg_window win_i (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .open_fire  (fires[2*w]),
            .close_fire (fires[2*w+1]),
            .active     (levels[w])
        );
    end

    assign sync_lvl = levels[0];
    assign vis_lvl  = levels[1];

    // R2/R5: span counter moves only on a step
    a_r5_span_idle: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> $stable(tot_q));

endmodule

// File: rtl/vtg_addr.sv
module vtg_addr #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de,
    input  logic              line_wrap,
    input  logic              frame_wrap,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] offs_q;
    logic [ADDR_W-1:0] offs_end;

    // Offset including the pixel being shown on the wrap edge
    assign offs_end = offs_q + (de ? ADDR_W'(1) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            offs_q <= '0;
        end else if (line_wrap) begin
            base_q <= frame_wrap ? '0 : (base_q + offs_end);
            offs_q <= '0;
        end else if (de) begin
            offs_q <= offs_q + ADDR_W'(1);
        end
    end

    assign addr = base_q + offs_q;

    // R7: consecutive visible pixels in a line take consecutive addresses
    a_r7_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (de && !line_wrap) |=> (addr == $past(addr) + ADDR_W'(1)));

    // R7: a new frame starts its addresses at zero
    a_r7_frame_zero: assert property (@(posedge clk) disable iff (rst)
        (frame_wrap) |=> (addr == '0));

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen #(
    parameter int unsigned CHAR_PIX = vtg_pkg::DEF_CHAR_PIX,
    parameter int unsigned H_CW     = 8,
    parameter int unsigned V_CW     = 10,
    parameter int unsigned ADDR_W   = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [H_CW-1:0]   h_total,
    input  logic [H_CW-1:0]   h_sync_on,
    input  logic [H_CW-1:0]   h_sync_off,
    input  logic [H_CW-1:0]   h_vis_on,
    input  logic [H_CW-1:0]   h_vis_off,
    input  logic [V_CW-1:0]   v_total,
    input  logic [V_CW-1:0]   v_sync_on,
    input  logic [V_CW-1:0]   v_sync_off,
    input  logic [V_CW-1:0]   v_vis_on,
    input  logic [V_CW-1:0]   v_vis_off,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [ADDR_W-1:0] pix_addr
);
    logic ctick;
    logic h_vis;
    logic v_vis;
    logic h_wrap;
    logic v_wrap;

    // Character prescaler
    if (CHAR_PIX <= 1) begin : g_no_pre
        assign ctick = 1'b1;
    end else begin : g_pre
        localparam int unsigned PW = $clog2(CHAR_PIX);
        logic [PW-1:0] px_q;
        assign ctick = (px_q == PW'(CHAR_PIX - 1));
        always_ff @(posedge clk) begin
            if (rst || ctick) begin
                px_q <= '0;
            end else begin
                px_q <= px_q + PW'(1);
            end
        end
    end

    vtg_axis #(.CW(H_CW)) h_axis_i (
        .clk      (clk),
        .rst      (rst),
        .adv      (ctick),
        .total    (h_total),
        .sync_on  (h_sync_on),
        .sync_off (h_sync_off),
        .vis_on   (h_vis_on),
        .vis_off  (h_vis_off),
        .sync_lvl (hsync),
        .vis_lvl  (h_vis),
        .wrap     (h_wrap)
    );

    vtg_axis #(.CW(V_CW)) v_axis_i (
        .clk      (clk),
        .rst      (rst),
        .adv      (h_wrap),
        .total    (v_total),
        .sync_on  (v_sync_on),
        .sync_off (v_sync_off),
        .vis_on   (v_vis_on),
        .vis_off  (v_vis_off),
        .sync_lvl (vsync),
        .vis_lvl  (v_vis),
        .wrap     (v_wrap)
    );

    assign de = h_vis && v_vis;

    vtg_addr #(.ADDR_W(ADDR_W)) addr_i (
        .clk        (clk),
        .rst        (rst),
        .de         (de),
        .line_wrap  (h_wrap),
        .frame_wrap (v_wrap),
        .addr       (pix_addr)
    );

    // R2: horizontal levels change only on a character step
    a_r2_char_bound: assert property (@(posedge clk) disable iff (rst)
        (!ctick) |=> ($stable(hsync) && $stable(h_vis)));

    // R5: vertical levels change only where a line begins
    a_r5_line_bound: assert property (@(posedge clk) disable iff (rst)
        (!h_wrap) |=> ($stable(vsync) && $stable(v_vis)));

    // R5: a frame start is always also a line start
    a_r5_frame_on_line: assert property (@(posedge clk) disable iff (rst)
        v_wrap |-> h_wrap);

endmodule

// File: tb/vtg_timing_gen_tb_top.sv
`timescale 1ns/1ps
module vtg_timing_gen_tb_top;
    localparam int CP     = 4;
    localparam int H_CW   = 8;
    localparam int V_CW   = 10;
    localparam int ADDR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [H_CW-1:0] h_total, h_sync_on, h_sync_off, h_vis_on, h_vis_off;
    logic [V_CW-1:0] v_total, v_sync_on, v_sync_off, v_vis_on, v_vis_off;
    logic hsync, vsync, de;
    logic [ADDR_W-1:0] pix_addr;

    always #5 clk = ~clk;

    vtg_timing_gen #(.CHAR_PIX(CP), .H_CW(H_CW), .V_CW(V_CW), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst),
        .h_total(h_total), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off),
        .h_vis_on(h_vis_on), .h_vis_off(h_vis_off),
        .v_total(v_total), .v_sync_on(v_sync_on), .v_sync_off(v_sync_off),
        .v_vis_on(v_vis_on), .v_vis_off(v_vis_off),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_addr(pix_addr)
    );

    typedef struct {
        bit hs;
        bit vs;
        bit de;
        int addr;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase = "R1 reset";

    // Model state: latched presets, raster position, visible count
    int x = 0, y = 0, cnt = 0;
    bit prev_de = 0;
    int mh_tot, mh_son, mh_soff, mh_von, mh_voff;
    int mv_tot, mv_son, mv_soff, mv_von, mv_voff;

    function automatic bit in_win(int p, int on, int off);
        return (p >= on) && (p < off);
    endfunction

    task automatic latch_h();
        mh_tot = h_total; mh_son = h_sync_on; mh_soff = h_sync_off;
        mh_von = h_vis_on; mh_voff = h_vis_off;
    endtask

    task automatic latch_v();
        mv_tot = v_total; mv_son = v_sync_on; mv_soff = v_sync_off;
        mv_von = v_vis_on; mv_voff = v_vis_off;
    endtask

    // Driver side of the scoreboard: expected item for the cycle after each edge
    always @(posedge clk) begin
        exp_t e;
        int   c;
        if (rst) begin
            x = 0; y = 0; cnt = 0;
            latch_h(); latch_v();
        end else begin
            if (prev_de) cnt++;
            x++;
            if (x == (mh_tot + 1) * CP) begin
                x = 0;
                y++;
                if (y == mv_tot + 1) y = 0;
            end
            if (x == 0) latch_h();           // R6: horizontal sampled at line start
            if (x == 0 && y == 0) begin      // R6: vertical sampled at frame start
                latch_v();
                cnt = 0;
            end
        end
        c = x / CP;                          // R2: character index
        e.hs   = in_win(c, mh_son, mh_soff);
        e.vs   = in_win(y, mv_son, mv_soff);
        e.de   = in_win(c, mh_von, mh_voff) && in_win(y, mv_von, mv_voff);
        e.addr = cnt;
        prev_de = e.de;
        q.push_back(e);
    end

    task automatic check_bit(string what, string req, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s got %0b exp %0b at x=%0d y=%0d",
                     req, phase, what, got, exp, x, y);
        end
    endtask

    // Monitor side: pop and compare away from the active edge
    always @(negedge clk) begin
        if (!done && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check_bit("hsync", "R3", hsync, e.hs);
            check_bit("vsync", "R5", vsync, e.vs);
            check_bit("de",    "R4", de,    e.de);
            if (e.de) begin
                checks++;
                if (int'(pix_addr) != e.addr) begin
                    errors++;
                    $display("FAIL R7 [%s] pix_addr got %0d exp %0d at x=%0d y=%0d",
                             phase, pix_addr, e.addr, x, y);
                end
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_h(int tot, int son, int soff, int von, int voff);
        h_total = H_CW'(tot); h_sync_on = H_CW'(son); h_sync_off = H_CW'(soff);
        h_vis_on = H_CW'(von); h_vis_off = H_CW'(voff);
    endtask

    task automatic set_v(int tot, int son, int soff, int von, int voff);
        v_total = V_CW'(tot); v_sync_on = V_CW'(son); v_sync_off = V_CW'(soff);
        v_vis_on = V_CW'(von); v_vis_off = V_CW'(voff);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        // R1: reset state with an ordinary layout
        set_h(9, 1, 3, 4, 9);
        set_v(7, 0, 1, 2, 6);
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        phase = "R2 R3 R4 R5 basic";
        run(3 * 320);

        // R6: horizontal and vertical presets changed in the middle of a line
        run(13);
        phase = "R6 mid-line change";
        set_h(9, 6, 8, 2, 7);
        set_v(7, 3, 5, 1, 7);
        run(3 * 320);

        // R8: close presets beyond the totals, window open to the end; R3 empty sync
        phase = "R8 far presets";
        set_h(9, 5, 5, 0, 200);
        set_v(7, 2, 900, 0, 300);
        run(3 * 320);

        // R3: close before open keeps sync low; R7 addresses on full-width lines
        phase = "R3 inverted window";
        set_h(7, 6, 2, 1, 8);
        set_v(5, 4, 1, 1, 5);
        run(3 * 192);

        // R1: reset in the middle of a frame
        run(37);
        phase = "R1 mid-frame reset";
        rst = 1'b1;
        set_h(9, 0, 2, 3, 9);
        set_v(7, 6, 7, 0, 5);
        run(2);
        rst = 1'b0;
        run(2 * 320);

        // R2: widest 8-bit line, sync late in the line
        phase = "R2 max line";
        set_h(255, 254, 255, 10, 250);
        set_v(2, 1, 2, 0, 2);
        run(3 * 1024 * 3 + 50);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_run();
        end
    end
endmodule